// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial bus in front of a 128-byte nonvolatile array. It oversamples the bus clock and data lines with the system clock and recognises START and STOP conditions. It decodes a control byte, loads a word pointer, acknowledges bytes and shifts read data back to the master. Write data is handed byte by byte to a separate page-write block, which is then told to commit when the master ends the transaction with STOP.

The data line is driven only through an open-drain enable. The array is read through a combinational read port addressed by the engine's pointer. While the page-write block is busy with a self-timed write, `busy_i` keeps the engine from acknowledging, so a master can poll for completion. A level input, `wr_en_i`, gates whether received data bytes are forwarded at all. When it is low, the array behaves as read-only.

Top module: `eep_i2c_slave`

## Requirements
- R1: A control byte is accepted (acknowledged) only when its upper four bits equal the device code (default binary 1010); bits 3..1 are ignored; bit 0 selects read (1) or write (0). A mismatching control byte gets no acknowledge, and the engine stays silent until the next START.
- R2: While `busy_i` is high, no byte is acknowledged: SDA stays released in the acknowledge slot.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The engine changes its SDA drive only after an SCL falling edge or a bus condition, never in the middle of an SCL high phase.
- R4: In a write, the byte after the control byte is acknowledged and its low 7 bits load the word pointer.
- R5: Each following write data byte is acknowledged. It is forwarded as a one-cycle `pg_load` carrying the current pointer and the byte, and the pointer then advances by one.
- R6: STOP after at least one forwarded data byte produces a one-cycle `pg_commit`. No commit is issued otherwise.
- R7: With `wr_en_i` low, data bytes are still acknowledged, but none is forwarded and no commit follows, so the array keeps its contents.
- R8: A read with no preceding address returns the byte at the pointer, which is the last accessed location plus one.
- R9: An address-only write followed by a repeated START and a read control byte returns the byte at that address.
- R10: In a read, each master acknowledge makes the engine send the next byte, with the pointer wrapping from 127 to 0. Bytes go out MSB first.
- R11: A master no-acknowledge ends the read. SDA stays released until the next START, even if further clocks arrive.
- R12: A START at any bit position aborts the byte in progress, and the engine then decodes a fresh control byte.
- R13: After reset, SDA is released and neither `pg_load` nor `pg_commit` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy_i | input | 1 | Self-timed write in progress; suppresses acknowledges |
| wr_en_i | input | 1 | Write-enable level; low makes the array read-only |
| mem_raddr | output | 7 | Array read address (word pointer) |
| mem_rdata | input | 8 | Array read data for `mem_raddr` |
| pg_load | output | 1 | One-cycle strobe: write byte for the page buffer |
| pg_addr | output | 7 | Array address of the forwarded byte |
| pg_data | output | 8 | Forwarded byte |
| pg_commit | output | 1 | One-cycle strobe: start the write cycle |

## Verification
The bench builds the block with its defaults: a 7-bit pointer, a two-stage input synchroniser and device code 1010. The bus is run at 20 system clocks per SCL half period, which leaves the synchroniser latency well inside each phase. A 128-byte array lets one address byte of 0xFF reach the 127-to-0 wrap and show that bit 7 of the address is dropped. A memory model in the bench answers reads and applies the forwarded bytes on commit, so protected writes and page writes can be read back through the bus.

// File: rtl/eep_i2c_pkg.sv
package eep_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CTRL = 3'd1,
    ST_ADDR = 3'd2,
    ST_WDAT = 3'd3,
    ST_ACK  = 3'd4,
    ST_TX   = 3'd5,
    ST_MACK = 3'd6
  } eng_state_t;

  // control byte selects this device when its top nibble equals the code
  function automatic logic ctrl_match(input logic [7:0] b, input logic [3:0] code);
    return (b[7:4] == code);
  endfunction

  // bit 0 of the control byte: 1 = read
  function automatic logic ctrl_is_read(input logic [7:0] b);
    return b[0];
  endfunction

  // open-drain drive for a data bit: pull low when the bit is 0
  function automatic logic drive_for_bit(input logic bitv);
    return ~bitv;
  endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_q,
  output logic sda_q
);

  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] scl_pipe;
  logic [NS-1:0] sda_pipe;

  // idle bus is high, so the pipes reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[NS-2:0], scl_i};
      sda_pipe <= {sda_pipe[NS-2:0], sda_i};
      scl_q    <= scl_pipe[NS-1];
      sda_q    <= sda_pipe[NS-1];
    end
  end

  assign scl_s = scl_pipe[NS-1];
  assign sda_s = sda_pipe[NS-1];

endmodule

// File: rtl/eep_cond_det.sv
module eep_cond_det (
  input  logic scl_s,
  input  logic sda_s,
  input  logic scl_q,
  input  logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_held_high;

  assign scl_held_high = scl_s & scl_q;
  assign scl_rise      = scl_s & ~scl_q;
  assign scl_fall      = ~scl_s & scl_q;
  assign start_det     = scl_held_high & sda_q & ~sda_s;
  assign stop_det      = scl_held_high & ~sda_q & sda_s;

endmodule

// File: rtl/eep_xfer_fsm.sv
module eep_xfer_fsm
  import eep_i2c_pkg::*;
#(
  parameter int         ADDR_W   = 7,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              busy_i,
  input  logic              wr_en_i,
  input  logic [7:0]        mem_rdata,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              pg_load,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [7:0]        pg_data,
  output logic              pg_commit,
  output eng_state_t        state_o
);

  localparam int          CW       = 4;
  localparam logic [CW-1:0] BYTE_END = CW'(8);

  eng_state_t        state;
  eng_state_t        nxt;
  logic [CW-1:0]     cnt;
  logic [7:0]        shreg;
  logic [ADDR_W-1:0] ptr;
  logic              loaded;
  logic              mack;
  logic              rx_state;
  logic              byte_ok;

  assign rx_state = (state == ST_CTRL) || (state == ST_ADDR) || (state == ST_WDAT);
  assign byte_ok  = !busy_i && ((state != ST_CTRL) || ctrl_match(shreg, DEV_CODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      nxt       <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      ptr       <= '0;
      loaded    <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      pg_load   <= 1'b0;
      pg_addr   <= '0;
      pg_data   <= '0;
      pg_commit <= 1'b0;
    end else begin
      pg_load   <= 1'b0;
      pg_commit <= 1'b0;
      if (start_det) begin
        state  <= ST_CTRL;
        cnt    <= '0;
        sda_oe <= 1'b0;
        loaded <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        cnt       <= '0;
        sda_oe    <= 1'b0;
        pg_commit <= loaded;
        loaded    <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise && (cnt != BYTE_END)) begin
          shreg <= {shreg[6:0], sda_s};
          cnt   <= cnt + 1'b1;
        end else if (scl_fall && (cnt == BYTE_END)) begin
          cnt <= '0;
          if (byte_ok) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK;
            case (state)
              ST_CTRL: nxt <= ctrl_is_read(shreg) ? ST_TX : ST_ADDR;
              ST_ADDR: begin
                ptr <= shreg[ADDR_W-1:0];
                nxt <= ST_WDAT;
              end
              default: begin
                if (wr_en_i) begin
                  pg_load <= 1'b1;
                  pg_addr <= ptr;
                  pg_data <= shreg;
                  loaded  <= 1'b1;
                end
                ptr <= ptr + 1'b1;
                nxt <= ST_WDAT;
              end
            endcase
          end else begin
            state <= ST_IDLE;
          end
        end
      end else begin
        case (state)
          ST_ACK: begin
            if (scl_fall) begin
              cnt   <= '0;
              state <= nxt;
              if (nxt == ST_TX) begin
                shreg  <= mem_rdata;
                sda_oe <= drive_for_bit(mem_rdata[7]);
                ptr    <= ptr + 1'b1;
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == BYTE_END) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_MACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= drive_for_bit(shreg[6]);
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              cnt  <= CW'(1);
            end else if (scl_fall && (cnt == CW'(1))) begin
              cnt <= '0;
              if (mack) begin
                state  <= ST_TX;
                shreg  <= mem_rdata;
                sda_oe <= drive_for_bit(mem_rdata[7]);
                ptr    <= ptr + 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

  assign ptr_o   = ptr;
  assign state_o = state;

endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_i2c_pkg::*;
#(
  parameter int         ADDR_W      = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              busy_i,
  input  logic              wr_en_i,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata,
  output logic              pg_load,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [7:0]        pg_data,
  output logic              pg_commit
);

  logic       scl_s, sda_s, scl_q, sda_q;
  logic       scl_rise, scl_fall;
  logic       start_det, stop_det;
  eng_state_t state_w;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .scl_s (scl_s),
    .sda_s (sda_s),
    .scl_q (scl_q),
    .sda_q (sda_q)
  );

  eep_cond_det u_cond (
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  eep_xfer_fsm #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy_i    (busy_i),
    .wr_en_i   (wr_en_i),
    .mem_rdata (mem_rdata),
    .sda_oe    (sda_oe),
    .ptr_o     (mem_raddr),
    .pg_load   (pg_load),
    .pg_addr   (pg_addr),
    .pg_data   (pg_data),
    .pg_commit (pg_commit),
    .state_o   (state_w)
  );

endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk
  import eep_i2c_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       busy_i,
  input logic       wr_en_i,
  input logic       pg_load,
  input logic       pg_commit,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input eng_state_t state_w
);

  a_r3_drive_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  a_r3_conditions_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));

  a_r2_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && state_w == ST_ACK) |-> !$past(busy_i));

  a_r7_load_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pg_load |-> $past(wr_en_i));

  a_r6_commit_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
    pg_commit |-> $past(stop_det));

  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_IDLE) |-> !sda_oe);

  a_r12_start_resyncs: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && state_w == ST_CTRL));

endmodule

bind eep_i2c_slave eep_i2c_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .busy_i    (busy_i),
  .wr_en_i   (wr_en_i),
  .pg_load   (pg_load),
  .pg_commit (pg_commit),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state_w   (state_w)
);

// File: tb/eep_i2c_slave_tb.sv
`timescale 1ns/1ps
module eep_i2c_slave_tb;

  localparam int HALF = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       busy = 1'b0;
  logic       wen = 1'b1;
  logic       sda_oe;
  logic [6:0] mem_raddr;
  logic [7:0] mem_rdata;
  logic       pg_load, pg_commit;
  logic [6:0] pg_addr;
  logic [7:0] pg_data;
  wire        sda_line = sda_m & ~sda_oe;

  logic [7:0] bmem [128];
  logic [7:0] expm [128];
  logic [6:0] st_a [16];
  logic [7:0] st_d [16];
  int nst = 0, loads = 0, commits = 0, r3_viol = 0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  eep_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .busy_i(busy), .wr_en_i(wen), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .pg_load(pg_load), .pg_addr(pg_addr), .pg_data(pg_data), .pg_commit(pg_commit)
  );

  assign mem_rdata = bmem[mem_raddr];

  // page-write block model: stage bytes, write them on commit
  always @(posedge clk) begin
    if (pg_load) begin
      st_a[nst[3:0]] = pg_addr;
      st_d[nst[3:0]] = pg_data;
      nst++;
      loads++;
    end
    if (pg_commit) begin
      for (int i = 0; i < nst; i++) bmem[st_a[i]] = st_d[i];
      nst = 0;
      commits++;
    end
  end

  // R3: drive never changes while the clock line is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe != oe_prev) && scl_m) r3_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp; #(HALF); endtask

  task automatic bus_start;
    sda_m = 1'b1; hp; scl_m = 1'b1; hp; sda_m = 1'b0; hp; scl_m = 1'b0; hp;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hp; scl_m = 1'b1; hp; sda_m = 1'b1; hp;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp; scl_m = 1'b1; hp; scl_m = 1'b0;
    end
    sda_m = 1'b1; hp; scl_m = 1'b1; #(HALF/2);
    acked = ~sda_line;
    #(HALF/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hp; scl_m = 1'b1; #(HALF/2);
      b[i] = sda_line;
      #(HALF/2); scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; hp; scl_m = 1'b1; hp; scl_m = 1'b0; sda_m = 1'b1;
  endtask

  // address-only write, repeated START, read control byte
  task automatic set_ptr_and_read(input logic [7:0] addr, string req);
    logic a;
    bus_start; send_byte(8'hA0, a); chk({req, " addr ctrl ack"}, a, 1);
    send_byte(addr, a); chk({req, " addr ack"}, a, 1);
    bus_start; send_byte(8'hA1, a); chk({req, " read ctrl ack"}, a, 1);
  endtask

  task automatic t_reset;
    chk("R13 sda released", sda_oe, 0);
    chk("R13 no load", pg_load, 0);
    chk("R13 no commit", pg_commit, 0);
  endtask

  task automatic t_page_write;
    logic a;
    int l0 = loads, c0 = commits;
    bus_start;
    send_byte(8'hA0, a); chk("R1 write ctrl ack", a, 1);
    send_byte(8'h10, a); chk("R4 addr ack", a, 1);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'hC0 + 8'(i), a); chk("R5 data ack", a, 1);
      expm[16 + i] = 8'hC0 + 8'(i);
    end
    bus_stop; hp;
    chk("R5 loads forwarded", loads - l0, 3);
    chk("R6 one commit", commits - c0, 1);
    chk("R5 array byte 0x12", bmem[8'h12], 8'hC2);
  endtask

  task automatic t_random_seq_read;
    logic [7:0] d;
    set_ptr_and_read(8'h11, "R9");
    recv_byte(1'b1, d); chk("R9 random read 0x11", d, expm[8'h11]);
    recv_byte(1'b0, d); chk("R10 sequential 0x12", d, expm[8'h12]);
    bus_stop;
  endtask

  task automatic t_current_read;
    logic a; logic [7:0] d;
    bus_start; send_byte(8'hA1, a); chk("R8 ctrl ack", a, 1);
    recv_byte(1'b0, d); chk("R8 current address 0x13", d, expm[8'h13]);
    bus_stop;
  endtask

  task automatic t_ctrl_decode;
    logic a; logic [7:0] d;
    int c0 = commits;
    bus_start; send_byte(8'hB0, a); chk("R1 wrong code no ack", a, 0);
    send_byte(8'h00, a); chk("R1 silent after mismatch", a, 0);
    bus_stop;
    bus_start; send_byte(8'hAE, a); chk("R1 dont-care bits ack", a, 1);
    send_byte(8'h40, a); chk("R4 addr ack", a, 1);
    send_byte(8'h5A, a); bus_stop; hp;
    expm[8'h40] = 8'h5A;
    chk("R6 commit after write", commits - c0, 1);
    set_ptr_and_read(8'h40, "R1");
    recv_byte(1'b0, d); chk("R1 data via AE write", d, 8'h5A);
    bus_stop;
  endtask

  task automatic t_busy;
    logic a;
    busy = 1'b1;
    bus_start; send_byte(8'hA0, a); chk("R2 busy no ack", a, 0);
    bus_stop;
    busy = 1'b0;
    bus_start; send_byte(8'hA0, a); chk("R2 ack after busy", a, 1);
    bus_stop;
  endtask

  task automatic t_protect;
    logic a; logic [7:0] d;
    int l0 = loads, c0 = commits;
    wen = 1'b0;
    bus_start; send_byte(8'hA0, a); send_byte(8'h20, a);
    send_byte(8'h55, a); chk("R7 protected data ack", a, 1);
    bus_stop; hp;
    chk("R7 no load", loads - l0, 0);
    chk("R7 no commit", commits - c0, 0);
    wen = 1'b1;
    set_ptr_and_read(8'h20, "R7");
    recv_byte(1'b0, d); chk("R7 array unchanged", d, expm[8'h20]);
    bus_stop;
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    set_ptr_and_read(8'hFF, "R4");
    recv_byte(1'b1, d); chk("R4 addr bit7 dropped 0x7F", d, expm[127]);
    recv_byte(1'b1, d); chk("R10 wrap to 0", d, expm[0]);
    recv_byte(1'b0, d); chk("R10 next 1", d, expm[1]);
    // R11: after NACK the engine stays released under further clocks
    recv_byte(1'b0, d); chk("R11 released after nack", d, 8'hFF);
    chk("R11 sda_oe low", sda_oe, 0);
    bus_stop;
  endtask

  task automatic t_abort;
    logic a; logic [7:0] d;
    bus_start;
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; hp; scl_m = 1'b1; hp; scl_m = 1'b0;
    end
    bus_start; send_byte(8'hA0, a); chk("R12 ack after abort", a, 1);
    send_byte(8'h05, a);
    bus_start; send_byte(8'hA1, a);
    recv_byte(1'b0, d); chk("R12 read after resync", d, expm[5]);
    bus_stop;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      bmem[i] = 8'((i * 37 + 11) & 255);
      expm[i] = 8'((i * 37 + 11) & 255);
    end
    #33; t_reset;
    rst_n = 1'b1;
    #100;
    t_page_write;
    t_random_seq_read;
    t_current_read;
    t_ctrl_decode;
    t_busy;
    t_protect;
    t_wrap;
    t_abort;
    chk("R3 drive stable while SCL high", r3_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule